// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address. It reads two levels of translation tables that live in memory. A requester hands over one address at a time on a valid/ready request channel. The walker then uses a single-read memory port to fetch a first-level descriptor and, if that descriptor is usable, a second-level descriptor. It answers on a valid/ready response channel. A good answer carries the physical page number joined with the untouched page offset, plus the 4-bit domain tag taken from the second-level descriptor. A failed walk returns an error answer that tells which level failed.

The virtual address splits into three fields. The top 12 bits choose one of 4096 first-level descriptors. The next 8 bits choose one of 256 second-level descriptors. The low 12 bits are the byte offset in a 4 KB page. Every descriptor is one 32-bit word. The first-level table must start on a 16 KB boundary, and its start address comes from a table-base register that is written through a write strobe.

Each level has its own sticky fault flag and its own captured-address register, so software can see which stage of the walk failed. A two-bit write-one-to-clear input resets the flags.

The controller has six states:
- IDLE: waits for a request.
- FETCH1: drives the first-level read.
- WAIT1: waits for the first-level data.
- FETCH2: drives the second-level read.
- WAIT2: waits for the second-level data.
- REPLY: holds the answer.

Its transitions are:
- IDLE→FETCH1 when a request is accepted.
- FETCH1→WAIT1 when the memory port accepts the read.
- WAIT1→FETCH2 on a usable first-level descriptor.
- WAIT1→REPLY on an unusable first-level descriptor.
- FETCH2→WAIT2 when the memory port accepts the read.
- WAIT2→REPLY when the second-level data arrives.
- REPLY→IDLE when the response handshake completes.

Top module: `pgwalk_top`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` and `mem_rd_valid` are 0, and `flt_status` is 00.
- R2: The first-level read address is `{base[31:14], iova[31:20], 2'b00}`. A write to the table-base register keeps only `tbase_wdata[31:14]`, and bits 13:0 of the base read as zero.
- R3: A first-level descriptor is usable only when its bits 1:0 equal 01. The codes 00, 10 and 11 end the walk with `rsp_err`=1 and `rsp_err_lvl2`=0, and no second read is issued.
- R4: The second-level read address is `{dte[31:10], iova[19:12], 2'b00}`. Descriptor bits 9:2 are ignored.
- R5: A second-level descriptor is usable only when its bit 1 is 1. Otherwise the answer has `rsp_err`=1 and `rsp_err_lvl2`=1.
- R6: A good walk answers with `rsp_err`=0, `rsp_paddr` = `{pte[31:12], iova[11:0]}` and `rsp_domain` = `pte[7:4]`. Descriptor bits 11:8, 3:2 and 0 have no effect.
- R7: An error answer carries `rsp_paddr`=0 and `rsp_domain`=0.
- R8: A first-level fault sets `flt_status[0]` and loads `flt_addr_l1` with the IOVA. A second-level fault sets `flt_status[1]` and loads `flt_addr_l2`. Each flag stays set until it is cleared.
- R9: Driving `flt_clr[n]`=1 for a cycle clears `flt_status[n]`. If a fault of the same level is detected in that same cycle, the flag ends up set.
- R10: Only one walk is in flight. `req_ready` is 0 from the accepting edge until the cycle after the response handshake. The response holds steady while `rsp_ready` is 0.
- R11: A pending memory read keeps `mem_rd_valid` and `mem_rd_addr` steady until `mem_rd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbase_we | input | 1 | Table-base register write strobe |
| tbase_wdata | input | 32 | Table-base write value (bits 31:14 kept) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_iova | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Translation answer valid |
| rsp_ready | input | 1 | Requester takes the answer |
| rsp_paddr | output | 32 | Physical address (0 on error) |
| rsp_domain | output | 4 | Domain tag from the second-level descriptor |
| rsp_err | output | 1 | Walk failed |
| rsp_err_lvl2 | output | 1 | Failure was at level two (level one if 0) |
| mem_rd_valid | output | 1 | Descriptor read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 32 | Descriptor word address (byte address, word aligned) |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| flt_status | output | 2 | Sticky fault flags: bit 0 level one, bit 1 level two |
| flt_clr | input | 2 | Write-one-to-clear for `flt_status` |
| flt_addr_l1 | output | 32 | IOVA of the last level-one fault |
| flt_addr_l2 | output | 32 | IOVA of the last level-two fault |

## Verification
Two functions can land in the same cycle: software clearing a fault flag, and the walker raising that same flag when a descriptor comes back unusable. The bench provokes the overlap by having its memory model pulse `flt_clr` in exactly the cycle it returns the faulting descriptor. In one case it clears both bits on a level-one fault, and in another it clears bit 1 on a level-two fault. Afterwards it expects the faulting level's flag to be set and the other level's flag to follow the clear. The rest of the sweep covers every first-level index and every second-level index, with memory and requester stalls, and computes each expected address arithmetically.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
    localparam int unsigned VA_W      = 32;
    localparam int unsigned L1_IDX_W  = 12;
    localparam int unsigned L2_IDX_W  = 8;
    localparam int unsigned ENT_LG    = 2;
    localparam int unsigned DOM_W     = 4;
    localparam int unsigned DOM_LSB   = 4;
    localparam int unsigned PTE_V_BIT = 1;
    localparam int unsigned N_LVL     = 2;

    localparam int unsigned OFS_W     = VA_W - L1_IDX_W - L2_IDX_W;
    localparam int unsigned BASE_LG   = L1_IDX_W + ENT_LG;
    localparam int unsigned PT_LG     = L2_IDX_W + ENT_LG;
    localparam int unsigned BASE_HI_W = VA_W - BASE_LG;
    localparam int unsigned PT_HI_W   = VA_W - PT_LG;
    localparam int unsigned PG_W      = VA_W - OFS_W;

    localparam logic [1:0] DTE_CODE_OK = 2'b01;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH1,
        ST_WAIT1,
        ST_FETCH2,
        ST_WAIT2,
        ST_REPLY
    } walk_st_t;
endpackage

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm
    import pgwalk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             mem_rd_ready,
    input  logic             mem_rsp_valid,
    input  logic             dte_ok,
    input  logic             pte_ok,
    input  logic             rsp_ready,
    output walk_st_t         state,
    output logic             req_ready,
    output logic             mem_rd_valid,
    output logic             rsp_valid,
    output logic             ld_va,
    output logic             ld_dte,
    output logic             ld_pte,
    output logic [N_LVL-1:0] flt_evt
);
    walk_st_t nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (req_valid)     nxt = ST_FETCH1;
            ST_FETCH1: if (mem_rd_ready)  nxt = ST_WAIT1;
            ST_WAIT1:  if (mem_rsp_valid) nxt = dte_ok ? ST_FETCH2 : ST_REPLY;
            ST_FETCH2: if (mem_rd_ready)  nxt = ST_WAIT2;
            ST_WAIT2:  if (mem_rsp_valid) nxt = ST_REPLY;
            ST_REPLY:  if (rsp_ready)     nxt = ST_IDLE;
            default:                      nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        mem_rd_valid = 1'b0;
        rsp_valid    = 1'b0;
        ld_va        = 1'b0;
        ld_dte       = 1'b0;
        ld_pte       = 1'b0;
        flt_evt      = '0;
        unique case (state)
            ST_IDLE: begin
                req_ready = 1'b1;
                ld_va     = req_valid;
            end
            ST_FETCH1, ST_FETCH2: mem_rd_valid = 1'b1;
            ST_WAIT1: begin
                ld_dte     = mem_rsp_valid;
                flt_evt[0] = mem_rsp_valid && !dte_ok;
            end
            ST_WAIT2: begin
                ld_pte     = mem_rsp_valid;
                flt_evt[1] = mem_rsp_valid && !pte_ok;
            end
            ST_REPLY: rsp_valid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/pgwalk_dpath.sv
module pgwalk_dpath
    import pgwalk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_we,
    input  logic [VA_W-1:0]  base_wdata,
    input  logic [VA_W-1:0]  req_iova,
    input  logic             ld_va,
    input  logic             ld_dte,
    input  logic             ld_pte,
    input  walk_st_t         state,
    input  logic [VA_W-1:0]  mem_rsp_data,
    output logic [VA_W-1:0]  mem_rd_addr,
    output logic             dte_ok,
    output logic             pte_ok,
    output logic [VA_W-1:0]  va_q,
    output logic [VA_W-1:0]  rsp_paddr,
    output logic [DOM_W-1:0] rsp_domain,
    output logic             rsp_err,
    output logic             rsp_err_lvl2
);
    logic [BASE_HI_W-1:0] base_hi;
    logic [PT_HI_W-1:0]   pt_hi;
    logic                 unused_bits;

    assign unused_bits = ^{base_wdata[BASE_LG-1:0],
                           mem_rsp_data[PT_LG-1:DOM_LSB+DOM_W],
                           mem_rsp_data[DOM_LSB-1:PTE_V_BIT+1]};

    assign dte_ok = (mem_rsp_data[1:0] == DTE_CODE_OK);
    assign pte_ok = mem_rsp_data[PTE_V_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_hi      <= '0;
            va_q         <= '0;
            pt_hi        <= '0;
            rsp_paddr    <= '0;
            rsp_domain   <= '0;
            rsp_err      <= 1'b0;
            rsp_err_lvl2 <= 1'b0;
        end else begin
            if (base_we) base_hi <= base_wdata[VA_W-1:BASE_LG];
            if (ld_va)   va_q    <= req_iova;
            if (ld_dte) begin
                pt_hi <= mem_rsp_data[VA_W-1:PT_LG];
                if (!dte_ok) begin
                    rsp_paddr    <= '0;
                    rsp_domain   <= '0;
                    rsp_err      <= 1'b1;
                    rsp_err_lvl2 <= 1'b0;
                end
            end
            if (ld_pte) begin
                if (pte_ok) begin
                    rsp_paddr    <= {mem_rsp_data[VA_W-1:OFS_W], va_q[OFS_W-1:0]};
                    rsp_domain   <= mem_rsp_data[DOM_LSB +: DOM_W];
                    rsp_err      <= 1'b0;
                    rsp_err_lvl2 <= 1'b0;
                end else begin
                    rsp_paddr    <= '0;
                    rsp_domain   <= '0;
                    rsp_err      <= 1'b1;
                    rsp_err_lvl2 <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_FETCH1: mem_rd_addr = {base_hi, va_q[VA_W-1 -: L1_IDX_W], {ENT_LG{1'b0}}};
            ST_FETCH2: mem_rd_addr = {pt_hi, va_q[OFS_W +: L2_IDX_W], {ENT_LG{1'b0}}};
            default:   mem_rd_addr = '0;
        endcase
    end
endmodule

// File: rtl/pgwalk_fault.sv
module pgwalk_fault
    import pgwalk_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_LVL-1:0]           evt,
    input  logic [N_LVL-1:0]           clr,
    input  logic [VA_W-1:0]            va,
    output logic [N_LVL-1:0]           stat,
    output logic [N_LVL-1:0][VA_W-1:0] addr
);
    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat[g] <= 1'b0;
                addr[g] <= '0;
            end else if (evt[g]) begin
                stat[g] <= 1'b1;
                addr[g] <= va;
            end else if (clr[g]) begin
                stat[g] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
    import pgwalk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tbase_we,
    input  logic [31:0]      tbase_wdata,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_iova,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [31:0]      rsp_paddr,
    output logic [3:0]       rsp_domain,
    output logic             rsp_err,
    output logic             rsp_err_lvl2,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    output logic [31:0]      mem_rd_addr,
    input  logic             mem_rsp_valid,
    input  logic [31:0]      mem_rsp_data,
    output logic [1:0]       flt_status,
    input  logic [1:0]       flt_clr,
    output logic [31:0]      flt_addr_l1,
    output logic [31:0]      flt_addr_l2
);
    walk_st_t                 state;
    logic                     ld_va, ld_dte, ld_pte, dte_ok, pte_ok;
    logic [N_LVL-1:0]         flt_evt;
    logic [VA_W-1:0]          va_q;
    logic [N_LVL-1:0][VA_W-1:0] flt_addr;

    pgwalk_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .mem_rd_ready(mem_rd_ready), .mem_rsp_valid(mem_rsp_valid),
        .dte_ok(dte_ok), .pte_ok(pte_ok), .rsp_ready(rsp_ready),
        .state(state), .req_ready(req_ready), .mem_rd_valid(mem_rd_valid),
        .rsp_valid(rsp_valid), .ld_va(ld_va), .ld_dte(ld_dte),
        .ld_pte(ld_pte), .flt_evt(flt_evt)
    );

    pgwalk_dpath u_dpath (
        .clk(clk), .rst_n(rst_n), .base_we(tbase_we), .base_wdata(tbase_wdata),
        .req_iova(req_iova), .ld_va(ld_va), .ld_dte(ld_dte), .ld_pte(ld_pte),
        .state(state), .mem_rsp_data(mem_rsp_data), .mem_rd_addr(mem_rd_addr),
        .dte_ok(dte_ok), .pte_ok(pte_ok), .va_q(va_q), .rsp_paddr(rsp_paddr),
        .rsp_domain(rsp_domain), .rsp_err(rsp_err), .rsp_err_lvl2(rsp_err_lvl2)
    );

    pgwalk_fault u_fault (
        .clk(clk), .rst_n(rst_n), .evt(flt_evt), .clr(flt_clr), .va(va_q),
        .stat(flt_status), .addr(flt_addr)
    );

    assign flt_addr_l1 = flt_addr[0];
    assign flt_addr_l2 = flt_addr[1];
endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_paddr,
    input logic [3:0]  rsp_domain,
    input logic        rsp_err,
    input logic        rsp_err_lvl2,
    input logic        mem_rd_valid,
    input logic        mem_rd_ready,
    input logic [31:0] mem_rd_addr,
    input logic [1:0]  flt_status,
    input logic [1:0]  flt_clr
);
    a_r10_single_walk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready && !mem_rd_valid);

    a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr)
            && $stable(rsp_domain) && $stable(rsp_err) && $stable(rsp_err_lvl2));

    a_r11_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> mem_rd_addr[1:0] == 2'b00);

    a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> rsp_paddr == 32'h0 && rsp_domain == 4'h0);

    a_r8_sticky_l1: assert property (@(posedge clk) disable iff (!rst_n)
        flt_status[0] && !flt_clr[0] |=> flt_status[0]);

    a_r8_sticky_l2: assert property (@(posedge clk) disable iff (!rst_n)
        flt_status[1] && !flt_clr[1] |=> flt_status[1]);

    a_r8_flag_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_valid) && rsp_err |-> flt_status[rsp_err_lvl2]);
endmodule

bind pgwalk_top pgwalk_chk u_chk (.*);

// File: tb/pgwalk_top_test.sv
module pgwalk_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG       = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tbase_we = 1'b0;
    logic [31:0] tbase_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_iova = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [3:0]  rsp_domain;
    logic        rsp_err, rsp_err_lvl2;
    logic        mem_rd_valid;
    logic        mem_rd_ready = 1'b0;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic [1:0]  flt_status;
    logic [1:0]  flt_clr;
    logic [31:0] flt_addr_l1, flt_addr_l2;

    logic [1:0]  clr_manual = 2'b00;
    logic [1:0]  clr_rsp = 2'b00;
    logic [1:0]  clr_on_rsp = 2'b00;
    assign flt_clr = clr_manual | clr_rsp;

    int          checks = 0;
    int          failures = 0;
    logic [31:0] cur_base = '0;
    int          rd_cnt = 0;
    logic [31:0] rd_addr [0:1];
    logic [1:0]  exp_stat = 2'b00;
    logic [31:0] exp_a1 = '0, exp_a2 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pgwalk_top uut (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_dte(input logic [11:0] i);
        logic [1:0] code = (i[1:0] == 2'b11) ? i[3:2] : 2'b01;
        return {2'b10, 8'h00, i, 8'hA5, code};
    endfunction

    function automatic logic [31:0] mk_pte(input logic [11:0] i, input logic [7:0] j);
        logic        v    = (j[2:0] != 3'd5);
        logic [19:0] page = {i, j} ^ 20'h5A5A5;
        logic [3:0]  dom  = i[3:0] ^ j[7:4];
        return {page, 4'hC, dom, 2'b11, v, 1'b1};
    endfunction

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        if (a[31:14] == cur_base[31:14]) return mk_dte(a[13:2]);
        if (a[31:30] == 2'b10)           return mk_pte(a[21:10], a[9:2]);
        return 32'h0;
    endfunction

    // memory model: ready stalls, one-cycle read latency
    initial begin
        int          cyc = 0;
        bit          pend = 0;
        logic [31:0] pend_addr = '0;
        bit          prev_stall = 0;
        logic [31:0] prev_addr = '0;
        forever begin
            @(negedge clk);
            cyc++;
            mem_rsp_valid = 1'b0;
            clr_rsp = 2'b00;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(pend_addr);
                clr_rsp       = clr_on_rsp;
                pend = 0;
            end
            if (prev_stall)
                chk(mem_rd_valid && mem_rd_addr == prev_addr, "R11 read held", mem_rd_addr, prev_addr);
            mem_rd_ready = ((cyc % 5) != 2);
            prev_stall = mem_rd_valid && !mem_rd_ready;
            prev_addr  = mem_rd_addr;
            if (mem_rd_valid && mem_rd_ready) begin
                pend = 1;
                pend_addr = mem_rd_addr;
                if (rd_cnt < 2) rd_addr[rd_cnt] = mem_rd_addr;
                rd_cnt++;
            end
        end
    end

    task automatic walk(input logic [31:0] va, input int hold);
        logic [11:0] i     = va[31:20];
        logic [7:0]  j     = va[19:12];
        logic [31:0] dte   = mk_dte(i);
        logic        ok1   = (dte[1:0] == 2'b01);
        logic [31:0] pte   = mk_pte(dte[21:10], j);
        logic        ok2   = pte[1];
        logic [31:0] e_l1  = {cur_base[31:14], i, 2'b00};
        logic [31:0] e_l2  = {dte[31:10], j, 2'b00};
        logic [31:0] e_pa  = (ok1 && ok2) ? {pte[31:12], va[11:0]} : 32'h0;
        logic [3:0]  e_dom = (ok1 && ok2) ? pte[7:4] : 4'h0;
        logic [1:0]  set   = !ok1 ? 2'b01 : (!ok2 ? 2'b10 : 2'b00);
        logic [31:0] s_pa;
        rd_cnt = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready when idle", {31'b0, req_ready}, 32'h1);
        req_valid = 1'b1;
        req_iova  = va;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid) begin
            chk(req_ready == 1'b0, "R10 busy during walk", {31'b0, req_ready}, 32'h0);
            @(negedge clk);
        end
        for (int d = 0; d < hold; d++) begin
            s_pa = rsp_paddr;
            @(negedge clk);
            chk(rsp_valid && rsp_paddr == s_pa && !req_ready, "R10 response held", rsp_paddr, s_pa);
        end
        chk(rsp_err == !(ok1 && ok2), "R3/R5 err flag", {31'b0, rsp_err}, {31'b0, !(ok1 && ok2)});
        if (!ok1)
            chk(rsp_err_lvl2 == 1'b0, "R3 level one error", {31'b0, rsp_err_lvl2}, 32'h0);
        else if (!ok2)
            chk(rsp_err_lvl2 == 1'b1, "R5 level two error", {31'b0, rsp_err_lvl2}, 32'h1);
        if (ok1 && ok2) begin
            chk(rsp_paddr == e_pa, "R6 paddr", rsp_paddr, e_pa);
            chk(rsp_domain == e_dom, "R6 domain", {28'b0, rsp_domain}, {28'b0, e_dom});
        end else begin
            chk(rsp_paddr == 32'h0 && rsp_domain == 4'h0, "R7 zero on error", rsp_paddr, 32'h0);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(!rsp_valid && req_ready, "R10 idle after handshake", {30'b0, rsp_valid, req_ready}, 32'h1);
        chk(rd_cnt == (ok1 ? 2 : 1), "R3 read count", rd_cnt, ok1 ? 2 : 1);
        chk(rd_addr[0] == e_l1, "R2 first-level address", rd_addr[0], e_l1);
        if (ok1) chk(rd_addr[1] == e_l2, "R4 second-level address", rd_addr[1], e_l2);
        exp_stat = (exp_stat & ~clr_on_rsp) | set;
        if (set[0]) exp_a1 = va;
        if (set[1]) exp_a2 = va;
        chk(flt_status == exp_stat, "R8 fault flags", {30'b0, flt_status}, {30'b0, exp_stat});
        chk(flt_addr_l1 == exp_a1, "R8 level one address", flt_addr_l1, exp_a1);
        chk(flt_addr_l2 == exp_a2, "R8 level two address", flt_addr_l2, exp_a2);
    endtask

    task automatic write_base(input logic [31:0] v);
        @(negedge clk);
        tbase_we = 1'b1;
        tbase_wdata = v;
        @(negedge clk);
        tbase_we = 1'b0;
        cur_base = {v[31:14], 14'h0};
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R10 watchdog expired act=%h exp=%h", 32'h1, 32'h0);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && mem_rd_valid == 1'b0,
            "R1 handshake reset", {29'b0, req_ready, rsp_valid, mem_rd_valid}, 32'h4);
        chk(flt_status == 2'b00, "R1 flags reset", {30'b0, flt_status}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_rd_valid == 1'b0, "R1 after release", {30'b0, req_ready, mem_rd_valid}, 32'h2);

        // R2: low bits of the base write are dropped
        write_base(32'h0001_FFFF);
        for (int k = 0; k < 4096; k++) begin
            logic [31:0] t1 = k * 37;
            logic [31:0] t2 = k * 113;
            walk({k[11:0], t1[7:0], t2[11:0]}, k % 3);
        end

        write_base(32'h0002_BFFF);
        for (int j = 0; j < 256; j++) begin
            logic [31:0] t3 = j * 17;
            walk({12'h005, j[7:0], t3[11:0]}, j % 2);
        end

        // R9: plain clear
        @(negedge clk);
        clr_manual = 2'b11;
        @(negedge clk);
        clr_manual = 2'b00;
        exp_stat = 2'b00;
        chk(flt_status == 2'b00, "R9 clear", {30'b0, flt_status}, 32'h0);

        walk({12'h005, 8'h05, 12'h123}, 0);
        chk(flt_status == 2'b10, "R8 level two sets bit 1", {30'b0, flt_status}, 32'h2);

        // R9: clear in the same cycle as a level-one fault
        clr_on_rsp = 2'b11;
        walk({12'h003, 20'h0ABCD}, 1);
        chk(flt_status == 2'b01, "R9 set wins level one", {30'b0, flt_status}, 32'h1);

        // R9: clear in the same cycle as a level-two fault
        clr_on_rsp = 2'b10;
        walk({12'h009, 8'h0D, 12'h777}, 2);
        chk(flt_status == 2'b11, "R9 set wins level two", {30'b0, flt_status}, 32'h3);
        clr_on_rsp = 2'b00;

        finish_run();
    end
endmodule